// File: doc/BRIEF.md
# Indexed Address Translation Window Unit

This block holds two banks of address translation windows for a bridge: one bank for outbound traffic and one for inbound traffic, each with `NWIN` windows (at most 16). Software never addresses a window directly. It first writes a select register that names a bank and a window index. The eight-entry register aperture then reads and writes the base, target, limit, type and enable fields of that one window.

Each window covers the inclusive range from its 64-bit base up to its 32-bit limit. The upper 32 address bits must equal the upper half of the base, and the lower 32 bits must fall between the low half of the base and the limit. A lookup names a bank and an address, and one clock later the block returns a hit flag, a memory/configuration flag and an output address. Memory windows relocate the address to the target. Configuration windows build a configuration-space address from bus and device/function fields held in the target, plus the window offset masked to the configuration space size. When no window matches, the address passes through unchanged.

Top module: `atu_window_bank`

## Requirements
- R1: After reset every window in both banks has base 0, target 0, limit 0xFFFFFFFF, type 0 (memory) and is disabled, except inbound window 0, which is enabled.
- R2: Aperture offset 0 is the select register. Bit 31 picks the inbound bank (1) or the outbound bank (0), and bits [3:0] give the window index. A write keeps only the index bits below NWIN and bit 31. All other bits read back as zero.
- R3: Offsets 1/2 hold base bits [31:0]/[63:32] and offsets 3/4 hold target bits [31:0]/[63:32]. Offset 5 holds the 32-bit limit, offset 6 the 32-bit type word, and offset 7 the enable at bit 31. Each offset reads back the value last written to the selected window, and reading is combinational.
- R4: An enabled window matches an address when address[63:32] equals base[63:32] and base[31:0] <= address[31:0] <= limit. Both end points are included.
- R5: A window whose enable bit is 0 never matches.
- R6: A match on a window with type word 0 gives the output address target + (address − base), with the memory/configuration flag low.
- R7: A match on a window with a non-zero type word raises the configuration flag. The output address is {32'b0, target[31:24] bus, target[23:16] device/function, 4'b0, (address − base)[11:0]}.
- R8: When several enabled windows of the requested bank match, the lowest index is used.
- R9: A lookup that matches no window reports no hit and no configuration flag, and returns the input address unchanged.
- R10: A lookup considers only the bank named by its direction input. Its result appears with `res_valid` on the clock edge after `lk_valid` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Aperture write strobe |
| reg_addr | input | 3 | Aperture register offset |
| reg_wdata | input | 32 | Aperture write data |
| reg_rdata | output | 32 | Aperture read data for the selected window |
| lk_valid | input | 1 | Lookup request |
| lk_dir | input | 1 | Lookup bank: 1 inbound, 0 outbound |
| lk_addr | input | 64 | Lookup address |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_cfg | output | 1 | The matched window is configuration type |
| res_addr | output | 64 | Translated or passed-through address |

## Verification
Some properties are checked on every cycle:
- the one-cycle result timing,
- pass-through on a miss,
- the configuration flag never being raised without a hit,
- select-register masking,
- read-back of the register last written.

Other behaviour only shows up in the bench scenarios:
- the inclusive range edges,
- disabled windows,
- lowest-index priority between overlapping windows,
- the two address formats,
- bank separation.

The bench covers these with directed cases and with randomly programmed windows, and compares every result against a model in the bench.

// File: rtl/atu_window_bank.sv
module atu_window_bank #(
  parameter int NWIN   = 16,
  parameter int CFG_OW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  input  logic        lk_dir,
  input  logic [63:0] lk_addr,
  output logic        res_valid,
  output logic        res_hit,
  output logic        res_cfg,
  output logic [63:0] res_addr
);
  localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [2:0] A_SEL = 3'd0, A_BLO = 3'd1, A_BHI = 3'd2, A_TLO = 3'd3,
                         A_THI = 3'd4, A_LIM = 3'd5, A_TYP = 3'd6, A_ENA = 3'd7;

  logic [IW-1:0]   sel_idx;
  logic            sel_in;
  logic [63:0]     base_q [2][NWIN];
  logic [63:0]     tgt_q  [2][NWIN];
  logic [31:0]     lim_q  [2][NWIN];
  logic [31:0]     typ_q  [2][NWIN];
  logic [NWIN-1:0] en_q   [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx <= '0;
      sel_in  <= 1'b0;
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < NWIN; i++) begin
          base_q[d][i] <= '0;
          tgt_q[d][i]  <= '0;
          lim_q[d][i]  <= 32'hFFFF_FFFF;
          typ_q[d][i]  <= '0;
        end
      end
      en_q[0] <= '0;
      en_q[1] <= NWIN'(1);
    end else if (reg_we) begin
      case (reg_addr)
        A_SEL: begin
          sel_idx <= reg_wdata[IW-1:0];
          sel_in  <= reg_wdata[31];
        end
        A_BLO: base_q[sel_in][sel_idx][31:0]  <= reg_wdata;
        A_BHI: base_q[sel_in][sel_idx][63:32] <= reg_wdata;
        A_TLO: tgt_q[sel_in][sel_idx][31:0]   <= reg_wdata;
        A_THI: tgt_q[sel_in][sel_idx][63:32]  <= reg_wdata;
        A_LIM: lim_q[sel_in][sel_idx]         <= reg_wdata;
        A_TYP: typ_q[sel_in][sel_idx]         <= reg_wdata;
        default: en_q[sel_in][sel_idx]        <= reg_wdata[31];
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_SEL:   reg_rdata = {sel_in, 31'(sel_idx)};
      A_BLO:   reg_rdata = base_q[sel_in][sel_idx][31:0];
      A_BHI:   reg_rdata = base_q[sel_in][sel_idx][63:32];
      A_TLO:   reg_rdata = tgt_q[sel_in][sel_idx][31:0];
      A_THI:   reg_rdata = tgt_q[sel_in][sel_idx][63:32];
      A_LIM:   reg_rdata = lim_q[sel_in][sel_idx];
      A_TYP:   reg_rdata = typ_q[sel_in][sel_idx];
      default: reg_rdata = {en_q[sel_in][sel_idx], 31'b0};
    endcase
  end

  logic          m_hit;
  logic [IW-1:0] m_idx;

  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (en_q[lk_dir][i] &&
          base_q[lk_dir][i][63:32] == lk_addr[63:32] &&
          lk_addr[31:0] >= base_q[lk_dir][i][31:0] &&
          lk_addr[31:0] <= lim_q[lk_dir][i]) begin
        m_hit = 1'b1;
        m_idx = IW'(i);
      end
    end
  end

  wire [63:0] m_tgt = tgt_q[lk_dir][m_idx];
  wire [63:0] m_off = lk_addr - base_q[lk_dir][m_idx];
  wire        m_cfg = m_hit && (typ_q[lk_dir][m_idx] != 32'd0);
  wire [63:0] m_out = !m_hit ? lk_addr :
                      m_cfg  ? {32'b0, m_tgt[31:16], 16'(m_off[CFG_OW-1:0])} :
                               m_tgt + m_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_cfg   <= 1'b0;
      res_addr  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit  <= m_hit;
        res_cfg  <= m_cfg;
        res_addr <= m_out;
      end
    end
  end
endmodule

// File: rtl/atu_window_bank_chk.sv
module atu_window_bank_chk #(
  parameter int NWIN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        lk_valid,
  input logic [63:0] lk_addr,
  input logic        res_valid,
  input logic        res_hit,
  input logic        res_cfg,
  input logic [63:0] res_addr
);
  assert_sel_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd0 && $past(reg_we && reg_addr == 3'd0)) |->
      (reg_rdata[30:4] == 27'd0 && 32'(reg_rdata[3:0]) < NWIN));

  assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && $past(reg_addr) == reg_addr && reg_addr >= 3'd1 && reg_addr <= 3'd6)
      |-> reg_rdata == $past(reg_wdata));

  assert_cfg_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_cfg |-> res_hit);

  assert_miss_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_addr == $past(lk_addr));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(lk_valid));
endmodule

bind atu_window_bank atu_window_bank_chk #(.NWIN(NWIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
  .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
  .res_cfg(res_cfg), .res_addr(res_addr)
);

// File: tb/atu_window_bank_tb_top.sv
module atu_window_bank_tb_top;
  localparam int NWIN = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, reg_we, lk_valid, lk_dir;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [63:0] lk_addr, res_addr;
  logic        res_valid, res_hit, res_cfg;

  atu_window_bank #(.NWIN(NWIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_dir(lk_dir), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_cfg(res_cfg), .res_addr(res_addr)
  );

  int checks = 0, fails = 0;
  logic [63:0] mb [2][NWIN];
  logic [63:0] mt [2][NWIN];
  logic [31:0] ml [2][NWIN];
  logic [31:0] my [2][NWIN];
  logic        me [2][NWIN];
  logic        msel_in;
  int          msel_idx;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: begin msel_idx = int'(d[3:0]) & (NWIN - 1); msel_in = d[31]; end
      3'd1: mb[msel_in][msel_idx][31:0]  = d;
      3'd2: mb[msel_in][msel_idx][63:32] = d;
      3'd3: mt[msel_in][msel_idx][31:0]  = d;
      3'd4: mt[msel_in][msel_idx][63:32] = d;
      3'd5: ml[msel_in][msel_idx] = d;
      3'd6: my[msel_in][msel_idx] = d;
      default: me[msel_in][msel_idx] = d[31];
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic sel(input logic dir, input int idx);
    wr(3'd0, {dir, 27'd0, 4'(idx)});
  endtask

  task automatic prog(input logic dir, input int idx, input logic [63:0] b, input logic [63:0] t,
                      input logic [31:0] l, input logic [31:0] ty, input logic en);
    sel(dir, idx);
    wr(3'd1, b[31:0]); wr(3'd2, b[63:32]);
    wr(3'd3, t[31:0]); wr(3'd4, t[63:32]);
    wr(3'd5, l); wr(3'd6, ty); wr(3'd7, {en, 31'd0});
  endtask

  task automatic model(input logic dir, input logic [63:0] a,
                       output logic h, output logic c, output logic [63:0] o);
    logic [63:0] off;
    h = 1'b0; c = 1'b0; o = a;
    for (int i = 0; i < NWIN; i++) begin
      if (!h && me[dir][i] && mb[dir][i][63:32] == a[63:32] &&
          a[31:0] >= mb[dir][i][31:0] && a[31:0] <= ml[dir][i]) begin
        h = 1'b1;
        off = a - mb[dir][i];
        c = (my[dir][i] != 0);
        o = c ? {32'd0, mt[dir][i][31:24], mt[dir][i][23:16], 4'd0, off[11:0]}
              : mt[dir][i] + off;
      end
    end
  endtask

  task automatic look(input string req, input logic dir, input logic [63:0] a);
    logic h, c;
    logic [63:0] o;
    @(negedge clk);
    lk_valid = 1'b1; lk_dir = dir; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    model(dir, a, h, c, o);
    chk({req, " valid"}, 64'(res_valid), 64'd1);
    chk({req, " hit"}, 64'(res_hit), 64'(h));
    chk({req, " cfg"}, 64'(res_cfg), 64'(c));
    chk({req, " addr"}, res_addr, o);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_valid = 1'b0; lk_dir = 1'b0; lk_addr = '0;
    msel_in = 1'b0; msel_idx = 0;
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < NWIN; i++) begin
        mb[d][i] = '0; mt[d][i] = '0; ml[d][i] = 32'hFFFF_FFFF; my[d][i] = '0;
        me[d][i] = (d == 1 && i == 0);
      end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R10 res_valid idle after reset", 64'(res_valid), 64'd0);
    rd_chk("R1 select reset", 3'd0, 32'd0);
    sel(1'b0, 5);
    rd_chk("R1 base lo", 3'd1, 32'd0);
    rd_chk("R1 target hi", 3'd4, 32'd0);
    rd_chk("R1 limit", 3'd5, 32'hFFFF_FFFF);
    rd_chk("R1 type", 3'd6, 32'd0);
    rd_chk("R1 outbound disabled", 3'd7, 32'd0);
    sel(1'b1, 0);
    rd_chk("R1 inbound0 enabled", 3'd7, 32'h8000_0000);
    look("R1 inbound0 default", 1'b1, 64'h0000_0000_1234_5678);
    look("R9 outbound miss at reset", 1'b0, 64'h0000_0000_1234_5678);

    wr(3'd0, 32'hFFFF_FFF3);
    rd_chk("R2 select masked", 3'd0, 32'h8000_0003);
    wr(3'd0, 32'h7FFF_FFF6);
    rd_chk("R2 select outbound", 3'd0, 32'h0000_0006);

    prog(1'b0, 2, 64'h0000_0001_4000_0000, 64'hAAAA_0000_0000_1000, 32'h4000_FFFF, 32'd0, 1'b1);
    rd_chk("R3 base hi", 3'd2, 32'h0000_0001);
    rd_chk("R3 base lo", 3'd1, 32'h4000_0000);
    rd_chk("R3 target hi", 3'd4, 32'hAAAA_0000);
    rd_chk("R3 limit", 3'd5, 32'h4000_FFFF);
    look("R4 R6 at base", 1'b0, 64'h0000_0001_4000_0000);
    look("R4 R6 at limit", 1'b0, 64'h0000_0001_4000_FFFF);
    look("R4 above limit", 1'b0, 64'h0000_0001_4001_0000);
    look("R4 below base", 1'b0, 64'h0000_0001_3FFF_FFFF);
    look("R4 upper half differs", 1'b0, 64'h0000_0002_4000_0010);
    look("R10 other bank ignores", 1'b1, 64'h0000_0001_4000_0010);

    prog(1'b0, 7, 64'h0000_0000_8000_0000, 64'h0000_0000_0A28_0000, 32'h800F_FFFF, 32'd4, 1'b1);
    look("R7 config format", 1'b0, 64'h0000_0000_8003_4ABC);

    prog(1'b0, 9, 64'h0000_0000_8000_0000, 64'h1111_0000_0000_0000, 32'h80FF_FFFF, 32'd0, 1'b1);
    look("R8 lowest index wins", 1'b0, 64'h0000_0000_8000_0100);
    look("R8 only higher window", 1'b0, 64'h0000_0000_8010_0100);
    sel(1'b0, 7);
    wr(3'd7, 32'd0);
    look("R5 disabled skipped", 1'b0, 64'h0000_0000_8000_0100);
    sel(1'b1, 0);
    wr(3'd7, 32'd0);
    look("R5 R9 inbound all disabled", 1'b1, 64'h0000_0000_0000_0040);

    for (int k = 0; k < 40; k++) begin
      logic [31:0] blo;
      blo = $urandom & 32'hFFFF_0000;
      prog(1'($urandom), int'($urandom % NWIN), {32'($urandom % 3), blo},
           {$urandom, $urandom}, blo + ($urandom % 32'h10000),
           ($urandom % 4 == 0) ? 32'd1 : 32'd0, ($urandom % 5) != 0);
      for (int j = 0; j < 6; j++) begin
        logic d;
        int w;
        d = 1'($urandom);
        w = int'($urandom % NWIN);
        look("R4 R6 R7 R8 R9 random", d, mb[d][w] + 64'($urandom % 32'h14000) - 64'h2000);
      end
    end

    finish_run();
  end
endmodule